// File: doc/BRIEF.md
# Translation-Block Insertion Controller

This controller sits next to the second-level TLB. It decides when a cluster of translation entries should be staged into the second-level data cache as a translation line. Two events start a sequence: a TLB miss and a TLB eviction. For each event the controller first asks a cost predictor whether the page is costly to translate. The predictor's answer is a pair of per-page counters, walk frequency and average walk cost, which the controller compares against two programmable thresholds. On a costly verdict the controller probes the cache for a translation line that already covers the page.

If the probe misses, the controller takes one of two paths. For a TLB miss, it waits for the walk that the MMU has already started. For an eviction, it issues its own background walk. Once the walk completes, the controller asks for the cache line holding the fetched entries to be rewritten as a translation line. The rewrite sets the type bit and writes a virtual tag, the address-space ID and the page size. A walk that reports a fault ends the sequence with no rewrite.

Event intake and every request the controller issues use valid/ready handshakes. A request output holds its valid and its payload steady until the ready input is seen high at a clock edge. A miss is accepted only while the controller is idle. An eviction goes into a one-entry buffer, and its ready is low while that buffer is occupied. The responses from the predictor and the probe, and the walk completion, are single-cycle pulses. Each is honoured only in the state that waits for it.

Top module: `tbi_insert_ctrl`

## Requirements
- R1: After reset, all four request valids (predictor, probe, walk, rewrite) are low, and miss_ready and evict_ready are high.
- R2: An accepted event produces a predictor request that carries that event's VPN. If the predictor response is not costly, the controller returns to idle and issues no probe.
- R3: A page is costly only when the frequency is at least thr_freq and the cost is at least thr_cost, both compared unsigned. If either comparison fails, the verdict is not costly.
- R4: After a costly verdict, the next request is a cache probe carrying the event's VPN and ASID.
- R5: A probe response with the hit flag set ends the sequence. No walk request or rewrite follows, and the controller is idle the cycle after.
- R6: For a miss event whose probe misses, the controller issues no walk request. It waits for walk_done and then issues a rewrite.
- R7: For an eviction whose probe misses, the controller issues a walk request carrying the evicted VPN and ASID, and then waits for walk_done.
- R8: The rewrite carries the line index and page size reported with walk_done and the event's ASID. rw_tlb_type is 1. rw_vtag is the VPN shifted right by CLUST_W+SET_W bits, which is 23 bits at the default widths.
- R9: A walk_done with walk_fault set returns the controller to idle with no rewrite.
- R10: Only one event is processed at a time. miss_ready is low while busy, and each of the four request valids is high only on its own. evict_ready is low while the eviction buffer holds an entry.
- R11: If a held miss and a buffered eviction are both waiting when the controller becomes idle, the miss is served first.
- R12: A request whose ready is low keeps its valid high and its payload unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_freq | input | CNT_W | Walk-frequency threshold |
| thr_cost | input | CNT_W | Walk-cost threshold |
| miss_valid | input | 1 | TLB miss event valid |
| miss_ready | output | 1 | Miss accepted (controller idle) |
| miss_vpn | input | VPN_W | Missing page number |
| miss_asid | input | ASID_W | Missing address-space ID |
| evict_valid | input | 1 | TLB eviction event valid |
| evict_ready | output | 1 | Eviction buffer empty |
| evict_vpn | input | VPN_W | Evicted page number |
| evict_asid | input | ASID_W | Evicted address-space ID |
| pred_req_valid | output | 1 | Predictor query valid |
| pred_req_ready | input | 1 | Predictor query accepted |
| pred_req_vpn | output | VPN_W | Queried page |
| pred_rsp_valid | input | 1 | Predictor answer pulse |
| pred_rsp_freq | input | CNT_W | Page walk-frequency counter |
| pred_rsp_cost | input | CNT_W | Page average walk-cost counter |
| probe_req_valid | output | 1 | Cache probe valid |
| probe_req_ready | input | 1 | Cache probe accepted |
| probe_req_vpn | output | VPN_W | Probed page |
| probe_req_asid | output | ASID_W | Probed address-space ID |
| probe_rsp_valid | input | 1 | Probe answer pulse |
| probe_rsp_hit | input | 1 | Translation line already present |
| walk_req_valid | output | 1 | Background walk request valid |
| walk_req_ready | input | 1 | Walk request accepted |
| walk_req_vpn | output | VPN_W | Page to walk |
| walk_req_asid | output | ASID_W | Address-space ID to walk |
| walk_done | input | 1 | Walk completion pulse |
| walk_fault | input | 1 | Walk ended in a fault |
| walk_line | input | LIDX_W | Cache line holding the fetched entries |
| walk_psize | input | PS_W | Page size found by the walk |
| rw_valid | output | 1 | Line rewrite request valid |
| rw_ready | input | 1 | Rewrite accepted |
| rw_line | output | LIDX_W | Line to rewrite |
| rw_vtag | output | VT_W | Virtual tag for the line |
| rw_asid | output | ASID_W | Address-space ID field |
| rw_psize | output | PS_W | Page-size field |
| rw_tlb_type | output | 1 | Line type bit (1 = translation) |

## Verification
The bench builds the controller with VPN_W=20, CLUST_W=3 and SET_W=4, which gives a 13-bit virtual tag. It also uses ASID_W=6, PS_W=2, CNT_W=8 and LIDX_W=8. With these narrow widths, VPNs whose low cluster and set bits are set, and an all-ones VPN, fit easily in the stimulus, so the tag shift boundary can be checked directly. With 8-bit counters, thresholds of 20 and 50 leave room to test values just below, exactly at, and above each threshold. The event ordering checks rely on short sequences in which a miss is held and an eviction is buffered while an earlier event is still in progress.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRED_REQ, ST_PRED_WAIT, ST_PROBE_REQ,
    ST_PROBE_WAIT, ST_WALK_REQ, ST_WALK_WAIT, ST_REWRITE
  } tbi_state_e;

  typedef enum logic {EV_MISS = 1'b0, EV_EVICT = 1'b1} tbi_src_e;
endpackage

// File: rtl/tbi_evt_arb.sv
module tbi_evt_arb
  import tbi_pkg::*;
#(
  parameter int VPN_W  = 36,
  parameter int ASID_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              miss_valid,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ASID_W-1:0] miss_asid,
  output logic              miss_ready,
  input  logic              evict_valid,
  input  logic [VPN_W-1:0]  evict_vpn,
  input  logic [ASID_W-1:0] evict_asid,
  output logic              evict_ready,
  output logic              ev_valid,
  output tbi_src_e          ev_src,
  output logic [VPN_W-1:0]  ev_vpn,
  output logic [ASID_W-1:0] ev_asid
);
  logic              buf_v;
  logic [VPN_W-1:0]  buf_vpn;
  logic [ASID_W-1:0] buf_asid;
  logic              pop;

  assign evict_ready = !buf_v;
  assign miss_ready  = take;
  assign ev_valid    = take && (miss_valid || buf_v);
  assign ev_src      = miss_valid ? EV_MISS : EV_EVICT;
  assign ev_vpn      = miss_valid ? miss_vpn : buf_vpn;
  assign ev_asid     = miss_valid ? miss_asid : buf_asid;
  assign pop         = take && !miss_valid && buf_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_vpn  <= '0;
      buf_asid <= '0;
    end else if (evict_valid && evict_ready) begin
      buf_v    <= 1'b1;
      buf_vpn  <= evict_vpn;
      buf_asid <= evict_asid;
    end else if (pop) begin
      buf_v <= 1'b0;
    end
  end
endmodule

// File: rtl/tbi_cost_cmp.sv
module tbi_cost_cmp #(
  parameter int NF    = 2,
  parameter int CNT_W = 16
) (
  input  logic [NF-1:0][CNT_W-1:0] feat,
  input  logic [NF-1:0][CNT_W-1:0] thr,
  output logic                     costly
);
  logic [NF-1:0] meet;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign meet[g] = (feat[g] >= thr[g]);
  end

  assign costly = &meet;
endmodule

// File: rtl/tbi_line_fmt.sv
module tbi_line_fmt #(
  parameter int VPN_W   = 36,
  parameter int TAG_LSB = 13,
  parameter int VT_W    = VPN_W - TAG_LSB
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [VT_W-1:0]  vtag
);
  logic [VPN_W-1:0] shifted;

  assign shifted = vpn >> TAG_LSB;
  assign vtag    = shifted[VT_W-1:0];
endmodule

// File: rtl/tbi_insert_ctrl.sv
module tbi_insert_ctrl
  import tbi_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int CLUST_W = 3,
  parameter int SET_W   = 10,
  parameter int ASID_W  = 11,
  parameter int PS_W    = 2,
  parameter int CNT_W   = 16,
  parameter int LIDX_W  = 14,
  localparam int TAG_LSB = CLUST_W + SET_W,
  localparam int VT_W    = VPN_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  thr_freq,
  input  logic [CNT_W-1:0]  thr_cost,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ASID_W-1:0] miss_asid,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic [VPN_W-1:0]  evict_vpn,
  input  logic [ASID_W-1:0] evict_asid,
  output logic              pred_req_valid,
  input  logic              pred_req_ready,
  output logic [VPN_W-1:0]  pred_req_vpn,
  input  logic              pred_rsp_valid,
  input  logic [CNT_W-1:0]  pred_rsp_freq,
  input  logic [CNT_W-1:0]  pred_rsp_cost,
  output logic              probe_req_valid,
  input  logic              probe_req_ready,
  output logic [VPN_W-1:0]  probe_req_vpn,
  output logic [ASID_W-1:0] probe_req_asid,
  input  logic              probe_rsp_valid,
  input  logic              probe_rsp_hit,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [VPN_W-1:0]  walk_req_vpn,
  output logic [ASID_W-1:0] walk_req_asid,
  input  logic              walk_done,
  input  logic              walk_fault,
  input  logic [LIDX_W-1:0] walk_line,
  input  logic [PS_W-1:0]   walk_psize,
  output logic              rw_valid,
  input  logic              rw_ready,
  output logic [LIDX_W-1:0] rw_line,
  output logic [VT_W-1:0]   rw_vtag,
  output logic [ASID_W-1:0] rw_asid,
  output logic [PS_W-1:0]   rw_psize,
  output logic              rw_tlb_type
);
  tbi_state_e        st_q;
  tbi_src_e          src_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [LIDX_W-1:0] line_q;
  logic [PS_W-1:0]   ps_q;

  logic              idle;
  logic              ev_valid;
  tbi_src_e          ev_src;
  logic [VPN_W-1:0]  ev_vpn;
  logic [ASID_W-1:0] ev_asid;
  logic              costly;

  assign idle = (st_q == ST_IDLE);

  tbi_evt_arb #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (idle),
    .miss_valid  (miss_valid),
    .miss_vpn    (miss_vpn),
    .miss_asid   (miss_asid),
    .miss_ready  (miss_ready),
    .evict_valid (evict_valid),
    .evict_vpn   (evict_vpn),
    .evict_asid  (evict_asid),
    .evict_ready (evict_ready),
    .ev_valid    (ev_valid),
    .ev_src      (ev_src),
    .ev_vpn      (ev_vpn),
    .ev_asid     (ev_asid)
  );

  tbi_cost_cmp #(.NF(2), .CNT_W(CNT_W)) i_cmp (
    .feat   ({pred_rsp_cost, pred_rsp_freq}),
    .thr    ({thr_cost, thr_freq}),
    .costly (costly)
  );

  tbi_line_fmt #(.VPN_W(VPN_W), .TAG_LSB(TAG_LSB), .VT_W(VT_W)) i_fmt (
    .vpn  (vpn_q),
    .vtag (rw_vtag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= EV_MISS;
      vpn_q  <= '0;
      asid_q <= '0;
      line_q <= '0;
      ps_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (ev_valid) begin
          src_q  <= ev_src;
          vpn_q  <= ev_vpn;
          asid_q <= ev_asid;
          st_q   <= ST_PRED_REQ;
        end
        ST_PRED_REQ:  if (pred_req_ready) st_q <= ST_PRED_WAIT;
        ST_PRED_WAIT: if (pred_rsp_valid) st_q <= costly ? ST_PROBE_REQ : ST_IDLE;
        ST_PROBE_REQ: if (probe_req_ready) st_q <= ST_PROBE_WAIT;
        ST_PROBE_WAIT: if (probe_rsp_valid) begin
          if (probe_rsp_hit)          st_q <= ST_IDLE;
          else if (src_q == EV_EVICT) st_q <= ST_WALK_REQ;
          else                        st_q <= ST_WALK_WAIT;
        end
        ST_WALK_REQ: if (walk_req_ready) st_q <= ST_WALK_WAIT;
        ST_WALK_WAIT: if (walk_done) begin
          if (walk_fault) begin
            st_q <= ST_IDLE;
          end else begin
            line_q <= walk_line;
            ps_q   <= walk_psize;
            st_q   <= ST_REWRITE;
          end
        end
        ST_REWRITE: if (rw_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pred_req_valid  = (st_q == ST_PRED_REQ);
  assign pred_req_vpn    = vpn_q;
  assign probe_req_valid = (st_q == ST_PROBE_REQ);
  assign probe_req_vpn   = vpn_q;
  assign probe_req_asid  = asid_q;
  assign walk_req_valid  = (st_q == ST_WALK_REQ);
  assign walk_req_vpn    = vpn_q;
  assign walk_req_asid   = asid_q;
  assign rw_valid        = (st_q == ST_REWRITE);
  assign rw_line         = line_q;
  assign rw_asid         = asid_q;
  assign rw_psize        = ps_q;
  assign rw_tlb_type     = 1'b1;
endmodule

// File: rtl/tbi_insert_ctrl_chk.sv
module tbi_insert_ctrl_chk
  import tbi_pkg::*;
#(
  parameter int VPN_W  = 36,
  parameter int ASID_W = 11,
  parameter int PS_W   = 2,
  parameter int CNT_W  = 16,
  parameter int LIDX_W = 14,
  parameter int VT_W   = 23
) (
  input logic              clk,
  input logic              rst_n,
  input tbi_state_e        st_q,
  input logic [CNT_W-1:0]  thr_freq,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [VPN_W-1:0]  miss_vpn,
  input logic              evict_valid,
  input logic              evict_ready,
  input logic              pred_req_valid,
  input logic              pred_req_ready,
  input logic [VPN_W-1:0]  pred_req_vpn,
  input logic              pred_rsp_valid,
  input logic [CNT_W-1:0]  pred_rsp_freq,
  input logic              probe_req_valid,
  input logic              probe_rsp_valid,
  input logic              probe_rsp_hit,
  input logic              walk_req_valid,
  input logic              walk_done,
  input logic              walk_fault,
  input logic              rw_valid,
  input logic              rw_ready,
  input logic [LIDX_W-1:0] rw_line,
  input logic [VT_W-1:0]   rw_vtag,
  input logic [ASID_W-1:0] rw_asid,
  input logic [PS_W-1:0]   rw_psize
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pred_req_valid, probe_req_valid, walk_req_valid, rw_valid})); // R10

  AST_EVBUF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && evict_ready |=> !evict_ready); // R10

  AST_MISS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> pred_req_valid && pred_req_vpn == $past(miss_vpn)); // R11

  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req_valid && !pred_req_ready |=> pred_req_valid && $stable(pred_req_vpn)); // R12

  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid && !rw_ready |=> rw_valid && $stable({rw_line, rw_vtag, rw_asid, rw_psize})); // R12

  AST_LOW_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_PRED_WAIT && pred_rsp_valid && pred_rsp_freq < thr_freq
    |=> st_q == ST_IDLE && !probe_req_valid); // R3

  AST_HIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_PROBE_WAIT && probe_rsp_valid && probe_rsp_hit
    |=> st_q == ST_IDLE && !walk_req_valid && !rw_valid); // R5

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_WALK_WAIT && walk_done && walk_fault |=> st_q == ST_IDLE && !rw_valid); // R9
endmodule

bind tbi_insert_ctrl tbi_insert_ctrl_chk #(
  .VPN_W(VPN_W), .ASID_W(ASID_W), .PS_W(PS_W),
  .CNT_W(CNT_W), .LIDX_W(LIDX_W), .VT_W(VT_W)
) i_chk (.*);

// File: tb/test_tbi_insert_ctrl.sv
`timescale 1ns/1ps
module test_tbi_insert_ctrl;
  localparam int VPN_W = 20, CLUST_W = 3, SET_W = 4, ASID_W = 6;
  localparam int PS_W = 2, CNT_W = 8, LIDX_W = 8;
  localparam int TAG_LSB = CLUST_W + SET_W;
  localparam int VT_W = VPN_W - TAG_LSB;
  localparam int TF = 20, TC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] thr_freq = CNT_W'(TF), thr_cost = CNT_W'(TC);
  logic miss_valid = 0, evict_valid = 0;
  logic miss_ready, evict_ready;
  logic [VPN_W-1:0] miss_vpn = '0, evict_vpn = '0;
  logic [ASID_W-1:0] miss_asid = '0, evict_asid = '0;
  logic pred_req_valid, probe_req_valid, walk_req_valid, rw_valid;
  logic pred_req_ready = 0, probe_req_ready = 0, walk_req_ready = 0, rw_ready = 0;
  logic [VPN_W-1:0] pred_req_vpn, probe_req_vpn, walk_req_vpn;
  logic [ASID_W-1:0] probe_req_asid, walk_req_asid, rw_asid;
  logic pred_rsp_valid = 0, probe_rsp_valid = 0, probe_rsp_hit = 0;
  logic [CNT_W-1:0] pred_rsp_freq = '0, pred_rsp_cost = '0;
  logic walk_done = 0, walk_fault = 0;
  logic [LIDX_W-1:0] walk_line = '0, rw_line;
  logic [PS_W-1:0] walk_psize = '0, rw_psize;
  logic [VT_W-1:0] rw_vtag;
  logic rw_tlb_type;

  int checks = 0, fails = 0;

  typedef struct {int kind; logic [31:0] a, b, c, d;} item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  tbi_insert_ctrl #(.VPN_W(VPN_W), .CLUST_W(CLUST_W), .SET_W(SET_W), .ASID_W(ASID_W),
    .PS_W(PS_W), .CNT_W(CNT_W), .LIDX_W(LIDX_W)) i_tbi_insert_ctrl (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic item_t mk(int k, logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] d);
    item_t it;
    it.kind = k; it.a = a; it.b = b; it.c = c; it.d = d;
    return it;
  endfunction

  // kind 1 predictor (R2), 2 probe (R4), 3 walk (R7), 4 rewrite (R8)
  task automatic observe(item_t got);
    item_t e;
    string req;
    req = (got.kind == 1) ? "R2" : (got.kind == 2) ? "R4" : (got.kind == 3) ? "R7" : "R8";
    if (exp_q.size() == 0) begin
      check(0, {req, " unexpected request"}, 32'(got.kind), 0);
      return;
    end
    e = exp_q.pop_front();
    check(got.kind == e.kind, {req, " request kind"}, 32'(got.kind), 32'(e.kind));
    check(got.a == e.a && got.b == e.b && got.c == e.c && got.d == e.d,
          {req, " payload"}, got.a ^ got.b ^ got.c ^ got.d, e.a ^ e.b ^ e.c ^ e.d);
  endtask

  // monitor: samples 1 ns after each falling edge
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (pred_req_valid && pred_req_ready) observe(mk(1, 32'(pred_req_vpn), 0, 0, 0));
      if (probe_req_valid && probe_req_ready)
        observe(mk(2, 32'(probe_req_vpn), 32'(probe_req_asid), 0, 0));
      if (walk_req_valid && walk_req_ready)
        observe(mk(3, 32'(walk_req_vpn), 32'(walk_req_asid), 0, 0));
      if (rw_valid && rw_ready)
        observe(mk(4, 32'(rw_line), 32'(rw_vtag), 32'(rw_asid), {29'd0, rw_psize, rw_tlb_type}));
    end
  end

  function automatic logic vld(int k);
    case (k)
      1: return pred_req_valid;
      2: return probe_req_valid;
      3: return walk_req_valid;
      default: return rw_valid;
    endcase
  endfunction

  function automatic logic [31:0] pay(int k);
    case (k)
      1: return 32'(pred_req_vpn);
      2: return {probe_req_asid, probe_req_vpn};
      3: return {walk_req_asid, walk_req_vpn};
      default: return {rw_psize, rw_asid, rw_vtag, rw_line};
    endcase
  endfunction

  task automatic set_rdy(int k, logic v);
    case (k)
      1: pred_req_ready = v;
      2: probe_req_ready = v;
      3: walk_req_ready = v;
      default: rw_ready = v;
    endcase
  endtask

  task automatic hs(int k, int delay);
    logic [31:0] p0;
    @(negedge clk); #1;
    while (!vld(k)) begin @(negedge clk); #1; end
    p0 = pay(k);
    repeat (delay) @(negedge clk);
    set_rdy(k, 1'b1); #1;
    check(vld(k) && pay(k) == p0, "R12 request held under back-pressure", pay(k), p0);
    @(negedge clk);
    set_rdy(k, 1'b0);
  endtask

  task automatic post_miss(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
    @(negedge clk);
    miss_vpn = v; miss_asid = a; miss_valid = 1'b1; #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic post_evict(logic [VPN_W-1:0] v, logic [ASID_W-1:0] a);
    @(negedge clk);
    evict_vpn = v; evict_asid = a; evict_valid = 1'b1; #1;
    while (!evict_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    evict_valid = 1'b0;
  endtask

  task automatic do_pred(logic [VPN_W-1:0] v, int fr, int co, int delay);
    exp_q.push_back(mk(1, 32'(v), 0, 0, 0));
    hs(1, delay);
    pred_rsp_freq = CNT_W'(fr); pred_rsp_cost = CNT_W'(co); pred_rsp_valid = 1'b1;
    @(negedge clk);
    pred_rsp_valid = 1'b0;
  endtask

  task automatic idle_check(string req);
    #1;
    check(miss_ready && !pred_req_valid && !probe_req_valid && !walk_req_valid && !rw_valid,
          {req, " idle after sequence"},
          {27'd0, miss_ready, pred_req_valid, probe_req_valid, walk_req_valid, rw_valid}, 32'h10);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_event(bit ev, logic [VPN_W-1:0] v, logic [ASID_W-1:0] a, int fr, int co,
                           bit hit, bit flt, int ln, int ps, int dly, string req);
    bit costly;
    if (ev) post_evict(v, a); else post_miss(v, a);
    do_pred(v, fr, co, dly);
    costly = (fr >= TF) && (co >= TC);
    if (costly) begin
      exp_q.push_back(mk(2, 32'(v), 32'(a), 0, 0));
      hs(2, dly);
      probe_rsp_hit = hit; probe_rsp_valid = 1'b1;
      @(negedge clk);
      probe_rsp_valid = 1'b0;
      if (!hit) begin
        if (ev) begin
          exp_q.push_back(mk(3, 32'(v), 32'(a), 0, 0));
          hs(3, dly);
        end
        repeat (2) @(negedge clk);
        walk_done = 1'b1; walk_fault = flt;
        walk_line = LIDX_W'(ln); walk_psize = PS_W'(ps);
        @(negedge clk);
        walk_done = 1'b0; walk_fault = 1'b0;
        if (!flt) begin
          exp_q.push_back(mk(4, 32'(ln), 32'(v >> TAG_LSB), 32'(a), 32'({ps[PS_W-1:0], 1'b1})));
          hs(4, dly);
        end
      end
    end
    idle_check(req);
    check(exp_q.size() == 0, {req, " all expected requests seen"}, 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1 reset state
    check(!pred_req_valid && !probe_req_valid && !walk_req_valid && !rw_valid,
          "R1 request valids low", {28'd0, pred_req_valid, probe_req_valid, walk_req_valid, rw_valid}, 0);
    check(miss_ready && evict_ready, "R1 intake ready", {30'd0, miss_ready, evict_ready}, 3);

    // R2/R3: frequency one below threshold, cost high -> not costly
    run_event(0, 20'h12345, 6'd3, TF - 1, 200, 0, 0, 0, 0, 0, "R3");
    // R3: cost one below threshold
    run_event(0, 20'h0ABCD, 6'd4, 255, TC - 1, 0, 0, 0, 0, 1, "R3");
    // R4/R5: both exactly at threshold -> costly, probe hits
    run_event(0, 20'h5A5A5, 6'd9, TF, TC, 1, 0, 0, 0, 0, "R5");
    // R6/R8: miss, probe misses, walk ok; low tag bits set, back-pressure
    run_event(0, 20'h0007F, 6'd17, 40, 90, 0, 0, 8'h3C, 2, 3, "R6");
    run_event(0, 20'hFFFFF, 6'd63, 255, 255, 0, 0, 8'hFF, 3, 0, "R8");
    // R7/R8: eviction issues its own walk
    run_event(1, 20'hC3A81, 6'd33, 100, 100, 0, 0, 8'h51, 1, 2, "R7");
    // R9: faulting walks, eviction and miss
    run_event(1, 20'h24680, 6'd5, 30, 60, 0, 1, 8'h11, 1, 0, "R9");
    run_event(0, 20'h13579, 6'd6, 30, 60, 0, 1, 8'h22, 2, 1, "R9");

    // R10/R11: busy with A, buffer eviction E, hold miss B
    post_miss(20'h0000A, 6'd1);
    evict_vpn = 20'h0000E; evict_asid = 6'd2; evict_valid = 1'b1; #1;
    check(evict_ready, "R10 eviction buffer empty", 32'(evict_ready), 1);
    @(negedge clk);
    evict_valid = 1'b0;
    miss_vpn = 20'h0000B; miss_asid = 6'd3; miss_valid = 1'b1; #1;
    check(!evict_ready, "R10 eviction buffer full", 32'(evict_ready), 0);
    check(!miss_ready, "R10 miss refused while busy", 32'(miss_ready), 0);
    do_pred(20'h0000A, 0, 0, 0);
    #1;
    check(miss_ready, "R11 held miss offered when idle", 32'(miss_ready), 1);
    @(negedge clk);
    miss_valid = 1'b0;
    do_pred(20'h0000B, 0, 0, 0);
    do_pred(20'h0000E, 0, 0, 0);
    idle_check("R11");
    check(exp_q.size() == 0 && evict_ready, "R11 order miss before eviction", 32'(exp_q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule